// File: doc/BRIEF.md
# Double-Precision Vector Compare Mask Generator

This block compares two operand vectors. Each vector carries several IEEE-754 binary64 lanes, two by default. For every lane it applies one of three quiet relational tests: equal, first-operand-greater ("high"), or first-operand-greater-or-equal ("high-or-equal"). Each lane of the result is a 64-bit mask, all ones when the test holds and all zeros when it does not. A 2-bit condition code summarises the lanes: all matched, some matched, or none matched.

A single-element mode restricts the work to lane 0. In that mode the remaining lanes of the result are forced to zero, and a lane-0 match counts as a full match. A signaling NaN in any evaluated lane raises an invalid-operation flag. Quiet NaNs only make the test false. Trap decisions are left to the surrounding logic. A request is presented with a one-cycle valid strobe, and the registered results appear on the next cycle.

Top module: `fpcmp_mask_gen`

## Requirements
- R1: With op select 2'b00, a lane matches when both operands are equal and neither is a NaN. +0 and -0 count as equal. A matching lane is 64'hFFFF_FFFF_FFFF_FFFF and a non-matching lane is 64'h0.
- R2: With op select 2'b01, a lane matches when operand B is less than operand A. With op select 2'b10, a lane matches when B is less than or equal to A. Ordering follows real-number value, with signed zeros equal and infinities at the ends.
- R3: A lane whose A or B is a NaN (exponent all ones, fraction nonzero) never matches, whatever the op select.
- R4: The invalid output is set when any evaluated lane has an operand that is a signaling NaN, meaning a NaN whose fraction MSB (bit 51) is clear. Quiet NaNs and lanes that are not evaluated do not set it.
- R5: When single-element mode is off, the condition code is 0 if every lane matched, 1 if some but not all matched, and 3 if none matched. It is never 2.
- R6: When single-element mode is on, only lane 0 is evaluated and all other result lanes are zero. The condition code is 0 on a lane-0 match and 3 otherwise.
- R7: Mask, condition code and invalid flag are registered on the clock edge where in_valid is high. out_valid is high for exactly the following cycle. Without in_valid, the results hold their previous values.
- R8: While rst_n is low at a clock edge, out_valid, mask, condition code and invalid all become zero.
- R9: Op select 2'b11 is reserved. No lane matches, so the condition code is 3 (0 lanes matched).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; operands sampled on this edge |
| op_sel | input | 2 | 00 equal, 01 high, 10 high-or-equal, 11 reserved |
| single_elem | input | 1 | Evaluate lane 0 only |
| opnd_a | input | 128 | Operand A lanes, lane 0 in bits 63:0 |
| opnd_b | input | 128 | Operand B lanes, lane 0 in bits 63:0 |
| out_valid | output | 1 | Results updated in this cycle |
| mask_out | output | 128 | Per-lane match masks, lane 0 in bits 63:0 |
| cc_out | output | 2 | Summary condition code |
| invalid_out | output | 1 | Signaling NaN seen in an evaluated lane |

## Verification
The hardest situations to reach are a signaling NaN or an unordered pair sitting in lane 1 while single-element mode is on. There the lane must be ignored for both the mask and the invalid flag, yet the same operands must count when the mode is off. The bench sweeps every pair from a set of special values (signed zeros, infinities, quiet and signaling NaNs, denormals, values of both signs) across lane 0. Lane 1 receives derived pairs, so each op and mode sees NaNs and zeros in the lane that is being suppressed. A reference model built on real-number comparison predicts every result.

// File: rtl/fpcmp_pkg.sv
// Shared types for the vector compare mask generator.
// Assumes binary64 lanes; encodings here are visible at the top ports.
package fpcmp_pkg;
    typedef enum logic [1:0] {
        CMP_EQ   = 2'b00,
        CMP_HI   = 2'b01,
        CMP_HE   = 2'b10,
        CMP_RSVD = 2'b11
    } cmp_op_e;

    localparam logic [1:0] CC_ALL  = 2'd0;
    localparam logic [1:0] CC_SOME = 2'd1;
    localparam logic [1:0] CC_NONE = 2'd3;
endpackage

// File: rtl/fpcmp_lane.sv
// One lane of quiet floating-point comparison.
// Compares B against A ("B < A", "B <= A", equality) by sign and magnitude.
// Assumes IEEE-754 layout {sign, exponent, fraction}; purely combinational.
module fpcmp_lane
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] a,
    input  logic [EXP_W+FRAC_W:0] b,
    input  cmp_op_e               op,
    output logic                  hit,
    output logic                  snan
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic a_nan, b_nan, a_snan, b_snan, both_zero, b_lt_a, equal;
    logic [W-2:0] mag_a, mag_b;

    // Classify each operand as NaN / signaling NaN.
    always_comb begin
        a_nan  = (&a[W-2:FRAC_W]) && (|a[FRAC_W-1:0]);
        b_nan  = (&b[W-2:FRAC_W]) && (|b[FRAC_W-1:0]);
        a_snan = a_nan && !a[FRAC_W-1];
        b_snan = b_nan && !b[FRAC_W-1];
        snan   = a_snan || b_snan;
    end

    // Order the two non-NaN values by sign, then by magnitude.
    always_comb begin
        mag_a     = a[W-2:0];
        mag_b     = b[W-2:0];
        both_zero = (mag_a == '0) && (mag_b == '0);
        equal     = both_zero || (a == b);
        if (both_zero)
            b_lt_a = 1'b0;
        else if (a[W-1] != b[W-1])
            b_lt_a = b[W-1];
        else if (!a[W-1])
            b_lt_a = mag_b < mag_a;
        else
            b_lt_a = mag_b > mag_a;
    end

    // Select the requested relation; any NaN makes it false.
    always_comb begin
        unique case (op)
            CMP_EQ:  hit = equal;
            CMP_HI:  hit = b_lt_a;
            CMP_HE:  hit = b_lt_a || equal;
            default: hit = 1'b0;
        endcase
        if (a_nan || b_nan)
            hit = 1'b0;
    end
endmodule

// File: rtl/fpcmp_cc.sv
// Condition-code summary of per-lane match bits.
// Assumes hit bits of non-evaluated lanes are already cleared.
module fpcmp_cc
    import fpcmp_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] hit,
    input  logic             single,
    output logic [1:0]       cc
);
    // Map all / some / none to the condition code.
    always_comb begin
        if (single)
            cc = hit[0] ? CC_ALL : CC_NONE;
        else if (&hit)
            cc = CC_ALL;
        else if (|hit)
            cc = CC_SOME;
        else
            cc = CC_NONE;
    end
endmodule

// File: rtl/fpcmp_mask_gen.sv
// Vector compare mask generator: per-lane quiet compare, mask expansion,
// condition code and invalid flag, registered one cycle after in_valid.
// Assumes lane 0 occupies the least significant bits of each vector.
module fpcmp_mask_gen
    import fpcmp_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [1:0]                    op_sel,
    input  logic                          single_elem,
    input  logic [LANES*(1+EXP_W+FRAC_W)-1:0] opnd_a,
    input  logic [LANES*(1+EXP_W+FRAC_W)-1:0] opnd_b,
    output logic                          out_valid,
    output logic [LANES*(1+EXP_W+FRAC_W)-1:0] mask_out,
    output logic [1:0]                    cc_out,
    output logic                          invalid_out
);
    localparam int W  = 1 + EXP_W + FRAC_W;
    localparam int VW = LANES * W;

    cmp_op_e            op;
    logic [LANES-1:0]   raw_hit, raw_snan, evaluated, hit;
    logic [VW-1:0]      mask_next;
    logic [1:0]         cc_next;
    logic               invalid_next;

    // Cast the op select to the enumerated type.
    always_comb op = cmp_op_e'(op_sel);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        fpcmp_lane #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_lane (
            .a    (opnd_a[l*W +: W]),
            .b    (opnd_b[l*W +: W]),
            .op   (op),
            .hit  (raw_hit[l]),
            .snan (raw_snan[l])
        );
        // Lane 0 is always evaluated; others only outside single mode.
        always_comb begin
            evaluated[l]         = (l == 0) || !single_elem;
            hit[l]               = raw_hit[l] && evaluated[l];
            mask_next[l*W +: W]  = {W{hit[l]}};
        end
    end

    // Invalid is raised only by evaluated lanes.
    always_comb invalid_next = |(raw_snan & evaluated);

    fpcmp_cc #(.LANES(LANES)) u_cc (
        .hit    (hit),
        .single (single_elem),
        .cc     (cc_next)
    );

    // Result registers: load on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            mask_out    <= '0;
            cc_out      <= 2'd0;
            invalid_out <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                mask_out    <= mask_next;
                cc_out      <= cc_next;
                invalid_out <= invalid_next;
            end
        end
    end
endmodule

// File: rtl/fpcmp_mask_gen_chk.sv
// Property checker for fpcmp_mask_gen, attached by bind below.
module fpcmp_mask_gen_chk #(
    parameter int LANES  = 2,
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               in_valid,
    input logic                               single_elem,
    input logic                               out_valid,
    input logic [LANES*(1+EXP_W+FRAC_W)-1:0]  mask_out,
    input logic [1:0]                         cc_out,
    input logic                               invalid_out
);
    localparam int W = 1 + EXP_W + FRAC_W;

    // R7: out_valid follows in_valid by one cycle.
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R7: results hold without a request.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(mask_out) && $stable(cc_out) && $stable(invalid_out)));

    // R5: code 2 never produced.
    p_cc_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cc_out != 2'd2));

    // R5: code 0 exactly when every lane mask is set.
    p_cc_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(single_elem)) |-> ((cc_out == 2'd0) == (&mask_out)));

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        // R1: each lane mask is uniform.
        p_lane_uniform_r1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (mask_out[l*W +: W] == '0 || mask_out[l*W +: W] == '1));
        if (l > 0) begin : g_upper
            // R6: upper lanes zero in single mode.
            p_single_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(single_elem)) |-> (mask_out[l*W +: W] == '0));
        end
    end
endmodule

bind fpcmp_mask_gen fpcmp_mask_gen_chk #(
    .LANES(LANES), .EXP_W(EXP_W), .FRAC_W(FRAC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .single_elem(single_elem),
    .out_valid(out_valid), .mask_out(mask_out), .cc_out(cc_out),
    .invalid_out(invalid_out)
);

// File: tb/fpcmp_mask_gen_test.sv
// Sweep bench for fpcmp_mask_gen with a real-number reference model.
module fpcmp_mask_gen_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic         single_elem = 1'b0;
    logic [127:0] opnd_a = '0, opnd_b = '0;
    logic         out_valid;
    logic [127:0] mask_out;
    logic [1:0]   cc_out;
    logic         invalid_out;
    int checks = 0, errors = 0;
    localparam int NV = 12;

    always #2.5 clk = ~clk;

    fpcmp_mask_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .single_elem(single_elem), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .out_valid(out_valid), .mask_out(mask_out), .cc_out(cc_out),
        .invalid_out(invalid_out)
    );

    function automatic logic [63:0] val(int k);
        case (k)
            0:  return 64'h0000_0000_0000_0000; // +0
            1:  return 64'h8000_0000_0000_0000; // -0
            2:  return 64'h3FF0_0000_0000_0000; // 1
            3:  return 64'hBFF0_0000_0000_0000; // -1
            4:  return 64'h4000_0000_0000_0000; // 2
            5:  return 64'hC000_0000_0000_0000; // -2
            6:  return 64'h7FF0_0000_0000_0000; // +inf
            7:  return 64'hFFF0_0000_0000_0000; // -inf
            8:  return 64'h7FF8_0000_0000_0001; // qNaN
            9:  return 64'hFFF0_0000_0000_0005; // sNaN
            10: return 64'h0000_0000_0000_0001; // min denormal
            default: return 64'hFFEF_FFFF_FFFF_FFFF; // -max
        endcase
    endfunction

    function automatic bit is_nan(logic [63:0] x);
        return (&x[62:52]) && (|x[51:0]);
    endfunction

    function automatic bit is_snan(logic [63:0] x);
        return is_nan(x) && !x[51];
    endfunction

    function automatic bit ref_hit(logic [63:0] a, logic [63:0] b, int op);
        real ra, rb;
        if (is_nan(a) || is_nan(b)) return 1'b0;
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        case (op)
            0: return ra == rb;
            1: return rb < ra;
            2: return rb <= ra;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(logic [63:0] a0, logic [63:0] b0, logic [63:0] a1,
                       logic [63:0] b1, int op, bit single);
        bit h0, h1, inv;
        logic [1:0] cc;
        string mtag;
        @(negedge clk);
        opnd_a = {a1, a0};
        opnd_b = {b1, b0};
        op_sel = op[1:0];
        single_elem = single;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        h0  = ref_hit(a0, b0, op);
        h1  = single ? 1'b0 : ref_hit(a1, b1, op);
        inv = is_snan(a0) || is_snan(b0) ||
              (!single && (is_snan(a1) || is_snan(b1)));
        if (single)         cc = h0 ? 2'd0 : 2'd3;
        else if (h0 && h1)  cc = 2'd0;
        else if (h0 || h1)  cc = 2'd1;
        else                cc = 2'd3;
        if (op == 3)                                   mtag = "R9";
        else if (single)                               mtag = "R6";
        else if (is_nan(a0) || is_nan(b0) || is_nan(a1) || is_nan(b1)) mtag = "R3";
        else if (op == 0)                              mtag = "R1";
        else                                           mtag = "R2";
        check("R7 out_valid", {127'd0, out_valid}, 128'd1);
        check(mtag, mask_out, {{64{h1}}, {64{h0}}});
        check(single ? "R6 cc" : "R5 cc", {126'd0, cc_out}, {126'd0, cc});
        check("R4 invalid", {127'd0, invalid_out}, {127'd0, inv});
    endtask

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 out_valid", {127'd0, out_valid}, 128'd0);
        check("R8 mask", mask_out, 128'd0);
        check("R8 cc", {126'd0, cc_out}, 128'd0);
        check("R8 invalid", {127'd0, invalid_out}, 128'd0);
        rst_n = 1'b1;
        for (int op = 0; op < 4; op++)
            for (int s = 0; s < 2; s++)
                for (int i = 0; i < NV; i++)
                    for (int j = 0; j < NV; j++) begin
                        run(val(i), val(j), val(j), val(i), op, s[0]);
                        run(val(i), val(j), val((i*5+1)%NV), val((j*7+2)%NV), op, s[0]);
                    end
        // R7: outputs hold while no request arrives
        run(val(2), val(0), val(4), val(4), 2, 1'b0);
        held = mask_out;
        @(negedge clk);
        opnd_a = '0;
        opnd_b = {64'h0, val(9)};
        op_sel = 2'b00;
        @(negedge clk);
        check("R7 hold mask", mask_out, held);
        check("R7 hold valid", {127'd0, out_valid}, 128'd0);
        check("R7 hold invalid", {127'd0, invalid_out}, 128'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule